// File: doc/BRIEF.md
# MAC Product Scaling and Saturation Unit

This block is the scaling and saturation datapath that sits beside the accumulate adder of a multiply-accumulate engine with four accumulators. It multiplies two 32-bit operands and presents the product in one of three interpretations. In signed-integer mode it checks that the product fits a 40-bit signed range. In unsigned-integer mode it checks a 40-bit unsigned range. In fractional mode it scales the product down by 24 bits, with optional round-half-to-even. When the overflow-control mode is on, an overflowing integer product is replaced by a large value. That value makes the following accumulate step overflow for certain.

The four accumulators hold the raw 64-bit sums that the external adder writes through a load port. On a saturate command the selected accumulator is reduced to its legal 48-bit range in the current mode. When overflow is seen, or was seen earlier, the result is clamped to a mode-dependent extreme. An 8-bit status word holds a sticky global overflow flag and one sticky per-accumulator overflow flag for each accumulator. Only a status write clears these flags.

Top module: `mac_scale_sat`

## Requirements
- R1: After reset all four accumulators read 0, the status word is 0 and `prodValid` is 0.
- R2: A `mulGo` in signed mode (`modeFrac`=0, `modeUnsigned`=0) puts the 64-bit signed product of `mulA` and `mulB` on `prodOut` with `prodValid`=1 in the next cycle. If the product lies outside [-2^39, 2^39-1], status bit 0 (V) is set.
- R3: In signed mode with `modeOmc`=1, an out-of-range product is replaced by 2^50 when positive and by the bitwise complement of 2^50 when negative.
- R4: In unsigned mode (`modeUnsigned`=1, `modeFrac`=0) the product is unsigned. Any set bit at position 40 or above sets V. The output is then 2^50 with `modeOmc`=1, or the product truncated to its low 40 bits with `modeOmc`=0.
- R5: In fractional mode (`modeFrac`=1) the output is the signed product shifted right arithmetically by 24 bits. With `modeRound`=1, a discarded 24-bit remainder above 0x800000 adds one, and a remainder of exactly 0x800000 adds one only when the shifted value is odd. A fractional product never sets V.
- R6: A signed-mode saturate (`satGo`) sets V when the selected accumulator does not fit 48 signed bits. Whenever V is then set, the accumulator's flag at status bit 4+`accIdx` is also set. With `modeOmc`=1 the accumulator becomes 2^31-1 if its 64-bit value is non-negative, else -2^31. Otherwise it becomes its low 48 bits sign-extended.
- R7: An unsigned-mode saturate sets V when any bit above 47 is set. When V is then set with `modeOmc`=1, values above 2^53 become 0 and all others become 2^48-1. In every other case the value is masked to 48 bits. The per-accumulator flag follows R6.
- R8: A fractional-mode saturate detects overflow as in R6. With V then set and `modeOmc`=1, it clamps to 2^47-1 for a non-negative value and to -2^47 for a negative one. Otherwise it sign-extends the low 48 bits.
- R9: V and the per-accumulator flags are sticky, so a saturate made while V is already set clamps even an in-range value. A status write replaces bits 0 and 7:4 (the other bits read 0). Flags raised in the same cycle as the write are ORed on top.
- R10: `accLoad` writes `accLoadData` into accumulator `accIdx`. A `satGo` in the same cycle is ignored and leaves the status unchanged.
- R11: `modeFrac`=1 takes precedence over `modeUnsigned`.
- R12: `accOut` always shows the accumulator selected by `accIdx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mulGo | input | 1 | Start a product this cycle |
| mulA | input | 32 | First operand |
| mulB | input | 32 | Second operand |
| modeUnsigned | input | 1 | Unsigned interpretation |
| modeFrac | input | 1 | Fractional interpretation |
| modeRound | input | 1 | Round fractional products |
| modeOmc | input | 1 | Overflow control (force or clamp) |
| accIdx | input | 2 | Accumulator select for load, saturate and read |
| accLoad | input | 1 | Load the selected accumulator |
| accLoadData | input | 64 | Raw sum to load |
| satGo | input | 1 | Saturate the selected accumulator |
| statWr | input | 1 | Write the status word |
| statWrData | input | 8 | Status write value |
| prodOut | output | 64 | Scaled product |
| prodValid | output | 1 | `prodOut` holds a new product |
| accOut | output | 64 | Selected accumulator |
| status | output | 8 | Bit 0 V, bits 7:4 per-accumulator flags |

## Verification
The product path is tried at each side of the 40-bit boundary, for example ±2^39. This shows whether range detection is off by one and whether the sign is handled in the bounds. Fractional operands whose remainders sit just above, exactly on and just below the half-way point tell truncation apart from round-up and from round-to-even, for both odd and even quotients and for a negative product. Saturation is run on in-range and out-of-range values with overflow control on and off. It is also run on an in-range value after V is already set, which shows whether the sticky flag drives the clamp. A long random mix of loads, saturations, products and status writes is compared every cycle against a behavioural model.

// File: rtl/mac_scale_pkg.sv
package mac_scale_pkg;

  typedef enum logic [1:0] {
    KIND_SINT = 2'd0,
    KIND_UINT = 2'd1,
    KIND_FRAC = 2'd2
  } prodKind_e;

  typedef struct packed {
    logic      mulEn;
    logic      loadEn;
    logic      satEn;
    logic      statWr;
    prodKind_e kind;
    logic      omc;
    logic      rnd;
  } strobe_t;

endpackage

// File: rtl/mac_scale_ctrl.sv
module mac_scale_ctrl
  import mac_scale_pkg::*;
(
  input  logic    mulGo,
  input  logic    modeUnsigned,
  input  logic    modeFrac,
  input  logic    modeRound,
  input  logic    modeOmc,
  input  logic    accLoad,
  input  logic    satGo,
  input  logic    statWr,
  output strobe_t strobe
);

  always_comb begin
    strobe.mulEn  = mulGo;
    strobe.loadEn = accLoad;
    // R10: a load in the same cycle wins over a saturate
    strobe.satEn  = satGo & ~accLoad;
    strobe.statWr = statWr;
    // R11: fractional interpretation overrides the unsigned one
    if (modeFrac)          strobe.kind = KIND_FRAC;
    else if (modeUnsigned) strobe.kind = KIND_UINT;
    else                   strobe.kind = KIND_SINT;
    strobe.omc = modeOmc;
    strobe.rnd = modeRound;
  end

endmodule

// File: rtl/mac_scale_dp.sv
module mac_scale_dp
  import mac_scale_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ACC_N      = 4,
  parameter int ACC_W      = 48,
  parameter int PROD_CAP   = 40,
  parameter int FORCE_BIT  = 50,
  parameter int FRAC_SH    = 24,
  parameter int UCLAMP_BIT = 53,
  parameter int PAV_OFS    = 4,
  parameter int STAT_W     = 8,
  parameter int V_BIT      = 0,
  parameter int IDX_W      = $clog2(ACC_N),
  parameter int SUM_W      = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] mulA,
  input  logic [DATA_W-1:0] mulB,
  input  logic [IDX_W-1:0]  accIdx,
  input  logic [SUM_W-1:0]  accLoadData,
  input  logic [STAT_W-1:0] statWrData,
  output logic [SUM_W-1:0]  prodOut,
  output logic              prodValid,
  output logic [SUM_W-1:0]  accOut,
  output logic [STAT_W-1:0] status
);

  localparam logic [SUM_W-1:0]  FORCE_VAL = SUM_W'(1) << FORCE_BIT;
  localparam logic [SUM_W-1:0]  U_MASK    = SUM_W'({ACC_W{1'b1}});
  localparam logic [SUM_W-1:0]  U_THRESH  = SUM_W'(1) << UCLAMP_BIT;
  localparam logic [SUM_W-1:0]  S32_MAX   = SUM_W'({(DATA_W-1){1'b1}});
  localparam logic [SUM_W-1:0]  S48_MAX   = SUM_W'({(ACC_W-1){1'b1}});
  localparam logic [FRAC_SH-1:0] HALF     = {1'b1, {(FRAC_SH-1){1'b0}}};
  localparam logic [STAT_W-1:0] V_MASK    = STAT_W'(1) << V_BIT;
  localparam logic [STAT_W-1:0] WR_MASK   =
    V_MASK | (STAT_W'((1 << ACC_N) - 1) << PAV_OFS);

  // ---------------- product scaling ----------------
  logic signed [SUM_W-1:0] sProd;
  logic        [SUM_W-1:0] uProd;
  logic        [SUM_W-1:0] fracQ;
  logic        [FRAC_SH-1:0] fracRem;
  logic                    fracInc;
  logic                    sInRange;
  logic                    uOver;
  logic        [SUM_W-1:0] prodNext;
  logic                    prodOv;

  assign sProd   = SUM_W'($signed(mulA)) * SUM_W'($signed(mulB));
  assign uProd   = SUM_W'(mulA) * SUM_W'(mulB);
  assign fracQ   = sProd >>> FRAC_SH;
  assign fracRem = sProd[FRAC_SH-1:0];
  assign fracInc = strobe.rnd &&
                   ((fracRem > HALF) || ((fracRem == HALF) && fracQ[0]));
  assign sInRange = (&sProd[SUM_W-1:PROD_CAP-1]) | ~(|sProd[SUM_W-1:PROD_CAP-1]);
  assign uOver    = |uProd[SUM_W-1:PROD_CAP];

  always_comb begin
    prodOv   = 1'b0;
    prodNext = sProd;
    unique case (strobe.kind)
      KIND_UINT: begin
        prodOv = uOver;
        if (uOver && strobe.omc) prodNext = FORCE_VAL;
        else                     prodNext = uProd & ((SUM_W'(1) << PROD_CAP) - SUM_W'(1));
      end
      KIND_FRAC: prodNext = fracQ + SUM_W'(fracInc);
      default: begin
        prodOv = ~sInRange;
        if (!sInRange && strobe.omc)
          prodNext = sProd[SUM_W-1] ? ~FORCE_VAL : FORCE_VAL;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prodOut   <= '0;
      prodValid <= 1'b0;
    end else begin
      prodValid <= strobe.mulEn;
      if (strobe.mulEn) prodOut <= prodNext;
    end
  end

  // ---------------- accumulator saturation ----------------
  logic [SUM_W-1:0] accQ [ACC_N];
  logic [SUM_W-1:0] cur, sext, clampVal, plainVal, satVal;
  logic             satOv, vAfter;
  logic [ACC_N-1:0] accWe;

  assign cur  = accQ[accIdx];
  assign sext = {{(SUM_W-ACC_W){cur[ACC_W-1]}}, cur[ACC_W-1:0]};

  always_comb begin
    unique case (strobe.kind)
      KIND_UINT: begin
        satOv    = |cur[SUM_W-1:ACC_W];
        clampVal = (cur > U_THRESH) ? '0 : U_MASK;
        plainVal = cur & U_MASK;
      end
      KIND_FRAC: begin
        satOv    = (sext != cur);
        clampVal = cur[SUM_W-1] ? ~S48_MAX : S48_MAX;
        plainVal = sext;
      end
      default: begin
        satOv    = (sext != cur);
        clampVal = cur[SUM_W-1] ? ~S32_MAX : S32_MAX;
        plainVal = sext;
      end
    endcase
    vAfter = status[V_BIT] | satOv;
    satVal = (vAfter && strobe.omc) ? clampVal : plainVal;
  end

  for (genvar g = 0; g < ACC_N; g++) begin : g_accWe
    assign accWe[g] = (strobe.loadEn || strobe.satEn) && (accIdx == IDX_W'(g));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ACC_N; i++) accQ[i] <= '0;
    end else begin
      for (int i = 0; i < ACC_N; i++)
        if (accWe[i]) accQ[i] <= strobe.loadEn ? accLoadData : satVal;
    end
  end

  assign accOut = cur;

  // ---------------- status ----------------
  logic [STAT_W-1:0] setBits, statNext;

  always_comb begin
    setBits = '0;
    if (strobe.mulEn && prodOv) setBits = setBits | V_MASK;
    if (strobe.satEn && vAfter)
      setBits = setBits | V_MASK | (STAT_W'(1) << (PAV_OFS + int'(accIdx)));
    statNext = (strobe.statWr ? (statWrData & WR_MASK) : status) | setBits;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) status <= '0;
    else       status <= statNext;
  end

endmodule

// File: rtl/mac_scale_sat.sv
module mac_scale_sat
  import mac_scale_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ACC_N   = 4,
  parameter int ACC_W   = 48,
  parameter int PAV_OFS = 4,
  parameter int STAT_W  = 8,
  parameter int V_BIT   = 0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  mulGo,
  input  logic [DATA_W-1:0]     mulA,
  input  logic [DATA_W-1:0]     mulB,
  input  logic                  modeUnsigned,
  input  logic                  modeFrac,
  input  logic                  modeRound,
  input  logic                  modeOmc,
  input  logic [$clog2(ACC_N)-1:0] accIdx,
  input  logic                  accLoad,
  input  logic [2*DATA_W-1:0]   accLoadData,
  input  logic                  satGo,
  input  logic                  statWr,
  input  logic [STAT_W-1:0]     statWrData,
  output logic [2*DATA_W-1:0]   prodOut,
  output logic                  prodValid,
  output logic [2*DATA_W-1:0]   accOut,
  output logic [STAT_W-1:0]     status
);

  strobe_t strobe;

  mac_scale_ctrl u_ctrl (
    .mulGo        (mulGo),
    .modeUnsigned (modeUnsigned),
    .modeFrac     (modeFrac),
    .modeRound    (modeRound),
    .modeOmc      (modeOmc),
    .accLoad      (accLoad),
    .satGo        (satGo),
    .statWr       (statWr),
    .strobe       (strobe)
  );

  mac_scale_dp #(
    .DATA_W  (DATA_W),
    .ACC_N   (ACC_N),
    .ACC_W   (ACC_W),
    .PAV_OFS (PAV_OFS),
    .STAT_W  (STAT_W),
    .V_BIT   (V_BIT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .mulA        (mulA),
    .mulB        (mulB),
    .accIdx      (accIdx),
    .accLoadData (accLoadData),
    .statWrData  (statWrData),
    .prodOut     (prodOut),
    .prodValid   (prodValid),
    .accOut      (accOut),
    .status      (status)
  );

endmodule

// File: rtl/mac_scale_sat_chk.sv
module mac_scale_sat_chk #(
  parameter int ACC_N   = 4,
  parameter int PAV_OFS = 4,
  parameter int STAT_W  = 8,
  parameter int V_BIT   = 0
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     mulGo,
  input logic                     modeUnsigned,
  input logic                     modeFrac,
  input logic                     modeOmc,
  input logic [$clog2(ACC_N)-1:0] accIdx,
  input logic                     accLoad,
  input logic                     satGo,
  input logic                     statWr,
  input logic [63:0]              prodOut,
  input logic                     prodValid,
  input logic [STAT_W-1:0]        status
);

  p_prod_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    mulGo |=> prodValid);

  p_prod_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !mulGo |=> !prodValid);

  p_unsigned_trunc_r4: assert property (@(posedge clk) disable iff (!rstN)
    (mulGo && modeUnsigned && !modeFrac && !modeOmc) |=> (prodOut[63:40] == '0));

  p_frac_no_v_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mulGo && modeFrac && !status[V_BIT] && !satGo && !statWr) |=> !status[V_BIT]);

  p_sticky_v_r9: assert property (@(posedge clk) disable iff (!rstN)
    (status[V_BIT] && !statWr) |=> status[V_BIT]);

  p_sticky_pav_r9: assert property (@(posedge clk) disable iff (!rstN)
    !statWr |=> ((status[PAV_OFS +: ACC_N] & $past(status[PAV_OFS +: ACC_N]))
                 == $past(status[PAV_OFS +: ACC_N])));

  p_pav_with_v_r6: assert property (@(posedge clk) disable iff (!rstN)
    (satGo && !accLoad && status[V_BIT]) |=>
      (status[V_BIT] && status[PAV_OFS + int'($past(accIdx))]));

  p_load_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (accLoad && satGo && !statWr && !mulGo) |=> $stable(status));

endmodule

bind mac_scale_sat mac_scale_sat_chk #(
  .ACC_N   (ACC_N),
  .PAV_OFS (PAV_OFS),
  .STAT_W  (STAT_W),
  .V_BIT   (V_BIT)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .mulGo        (mulGo),
  .modeUnsigned (modeUnsigned),
  .modeFrac     (modeFrac),
  .modeOmc      (modeOmc),
  .accIdx       (accIdx),
  .accLoad      (accLoad),
  .satGo        (satGo),
  .statWr       (statWr),
  .prodOut      (prodOut),
  .prodValid    (prodValid),
  .status       (status)
);

// File: tb/mac_scale_sat_test.sv
module mac_scale_sat_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mulGo = 1'b0;
  logic [31:0] mulA = '0, mulB = '0;
  logic        modeUnsigned = 1'b0, modeFrac = 1'b0, modeRound = 1'b0, modeOmc = 1'b0;
  logic [1:0]  accIdx = '0;
  logic        accLoad = 1'b0;
  logic [63:0] accLoadData = '0;
  logic        satGo = 1'b0;
  logic        statWr = 1'b0;
  logic [7:0]  statWrData = '0;
  logic [63:0] prodOut, accOut;
  logic        prodValid;
  logic [7:0]  status;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // reference state
  logic [63:0] mAcc [4];
  logic [7:0]  mStat;
  logic [63:0] mProd;
  logic        mPv;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_scale_sat uut (.*);

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] refProd(input logic [31:0] a, b,
      input bit uns, frac, rnd, omc, output bit ov);
    longint p, q, rem;
    longint unsigned pu;
    ov = 0;
    if (frac) begin
      p   = longint'($signed(a)) * longint'($signed(b));
      q   = p >>> 24;
      rem = p & 64'hFF_FFFF;
      if (rnd) begin
        if (rem > 64'h80_0000) q = q + 1;
        else if (rem == 64'h80_0000) q = q + (q & 1);
      end
      return q;
    end else if (uns) begin
      pu = longint'(a) * longint'(b);
      if (pu >= (64'd1 << 40)) begin
        ov = 1;
        if (omc) return 64'd1 << 50;
        return pu % (64'd1 << 40);
      end
      return pu;
    end else begin
      p = longint'($signed(a)) * longint'($signed(b));
      if (p < -(longint'(1) <<< 39) || p >= (longint'(1) <<< 39)) begin
        ov = 1;
        if (omc) return (p < 0) ? ~(64'd1 << 50) : (64'd1 << 50);
      end
      return p;
    end
  endfunction

  function automatic logic [63:0] refSat(input logic [63:0] v, input bit uns, frac,
      omc, vOld, output bit vAfter);
    longint sv, s48;
    longint unsigned uv;
    bit ov;
    sv  = v;
    uv  = v;
    s48 = (sv <<< 16) >>> 16;
    if (!frac && uns) begin
      ov = (uv >= (64'd1 << 48));
      vAfter = vOld | ov;
      if (vAfter && omc) return (uv > (64'd1 << 53)) ? 64'd0 : (64'd1 << 48) - 1;
      return uv % (64'd1 << 48);
    end
    ov = (s48 != sv);
    vAfter = vOld | ov;
    if (vAfter && omc) begin
      if (frac) return (sv < 0) ? -(longint'(1) <<< 47) : (longint'(1) <<< 47) - 1;
      return (sv < 0) ? -(longint'(1) <<< 31) : (longint'(1) <<< 31) - 1;
    end
    return s48;
  endfunction

  // advance one clock: update the reference, then compare away from the edge
  task automatic tick(input string tag);
    logic [7:0]  setBits;
    logic [63:0] nv;
    bit ov, vAfter;
    @(posedge clk);
    #1;
    setBits = '0;
    mPv = mulGo;
    if (mulGo) begin
      mProd = refProd(mulA, mulB, modeUnsigned, modeFrac, modeRound, modeOmc, ov);
      if (ov) setBits[0] = 1'b1;
    end
    if (accLoad) mAcc[accIdx] = accLoadData;
    else if (satGo) begin
      nv = refSat(mAcc[accIdx], modeUnsigned, modeFrac, modeOmc, mStat[0], vAfter);
      mAcc[accIdx] = nv;
      if (vAfter) begin
        setBits[0] = 1'b1;
        setBits[4 + accIdx] = 1'b1;
      end
    end
    mStat = (statWr ? (statWrData & 8'hF1) : mStat) | setBits;
    @(negedge clk);
    check(tag, "prodValid", 64'(prodValid), 64'(mPv));
    if (mPv) check(tag, "prodOut", prodOut, mProd);
    check(tag, "status", 64'(status), 64'(mStat));
    check(tag, "accOut", accOut, mAcc[accIdx]);
    mulGo = 0; accLoad = 0; satGo = 0; statWr = 0;
  endtask

  task automatic mul(input string tag, input logic [31:0] a, b,
                     input bit uns, frac, rnd, omc);
    mulA = a; mulB = b; modeUnsigned = uns; modeFrac = frac;
    modeRound = rnd; modeOmc = omc; mulGo = 1;
    tick(tag);
  endtask

  task automatic load(input string tag, input logic [1:0] idx, input logic [63:0] d);
    accIdx = idx; accLoadData = d; accLoad = 1;
    tick(tag);
  endtask

  task automatic sat(input string tag, input logic [1:0] idx, input bit uns, frac, omc);
    accIdx = idx; modeUnsigned = uns; modeFrac = frac; modeOmc = omc; satGo = 1;
    tick(tag);
  endtask

  task automatic wrStat(input string tag, input logic [7:0] d);
    statWrData = d; statWr = 1;
    tick(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) mAcc[i] = '0;
    mStat = '0; mProd = '0; mPv = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1: reset state on every accumulator
    for (int i = 0; i < 4; i++) begin
      accIdx = 2'(i);
      #1;
      check("R1", "accOut", accOut, 64'd0);
    end
    check("R1", "status", 64'(status), 64'd0);
    check("R1", "prodValid", 64'(prodValid), 64'd0);

    // R2: signed products around the 40-bit bound
    mul("R2", 32'd1000, -32'sd3, 0, 0, 0, 0);
    mul("R2", 32'h0008_0000, 32'hFFF0_0000, 0, 0, 0, 0);   // -2^39 fits
    mul("R2", 32'h0008_0000, 32'h0010_0000, 0, 0, 0, 0);   // 2^39 overflows
    wrStat("R9", 8'h00);
    // R3: forced values
    mul("R3", 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 0, 0, 1);
    mul("R3", 32'h7FFF_FFFF, 32'h8000_0000, 0, 0, 0, 1);
    wrStat("R9", 8'h00);
    // R4: unsigned
    mul("R4", 32'hFFFF_FFFF, 32'd200, 0, 0, 0, 0);
    mul("R4", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0, 0, 0);
    mul("R4", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0, 0, 1);
    mul("R4", 32'h0000_FFFF, 32'h00FF_FFFF, 1, 0, 0, 0);
    wrStat("R9", 8'h00);
    // R5: fractional truncation and rounding
    mul("R5", 32'h0080_0000, 32'd1, 0, 1, 1, 0);            // tie, even stays
    mul("R5", 32'h0180_0000, 32'd1, 0, 1, 1, 0);            // tie, odd rounds up
    mul("R5", 32'h0080_0001, 32'd1, 0, 1, 1, 0);            // above half
    mul("R5", 32'h0080_0001, 32'd1, 0, 1, 0, 0);            // truncate
    mul("R5", 32'hFF80_0000, 32'd1, 0, 1, 1, 0);            // negative tie
    mul("R5", 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 1, 0, 1);    // no V in fractional
    // R11: fractional wins over unsigned
    mul("R11", 32'hFFFF_FFFF, 32'h0100_0000, 1, 1, 0, 0);

    // R6: signed saturation
    load("R10", 2'd0, 64'h0000_7FFF_FFFF_FFFF);
    sat("R6", 2'd0, 0, 0, 1);
    load("R10", 2'd1, 64'h0000_8000_0000_0000);
    sat("R6", 2'd1, 0, 0, 1);
    wrStat("R9", 8'h00);
    load("R10", 2'd2, 64'hFFF0_0000_0000_0001);
    sat("R6", 2'd2, 0, 0, 0);
    wrStat("R9", 8'h00);
    // R7: unsigned saturation
    load("R10", 2'd3, 64'h0000_FFFF_FFFF_FFFF);
    sat("R7", 2'd3, 1, 0, 1);
    load("R10", 2'd3, 64'h0021_0000_0000_0000);
    sat("R7", 2'd3, 1, 0, 1);
    wrStat("R9", 8'h00);
    load("R10", 2'd3, 64'h0020_0000_0000_0000);
    sat("R7", 2'd3, 1, 0, 1);
    wrStat("R9", 8'h00);
    load("R10", 2'd3, 64'h0001_1234_5678_9ABC);
    sat("R7", 2'd3, 1, 0, 0);
    wrStat("R9", 8'h00);
    // R8: fractional saturation
    load("R10", 2'd0, 64'hFF00_0000_0000_0000);
    sat("R8", 2'd0, 0, 1, 1);
    load("R10", 2'd1, 64'h0001_0000_0000_0000);
    sat("R8", 2'd1, 1, 1, 1);
    // R9: sticky V clamps an in-range value
    load("R10", 2'd2, 64'd12345);
    sat("R9", 2'd2, 0, 0, 1);
    wrStat("R9", 8'hFF);
    wrStat("R9", 8'h00);
    load("R10", 2'd2, 64'd12345);
    sat("R9", 2'd2, 0, 0, 1);
    // R9: write and overflow in the same cycle
    statWrData = 8'h00; statWr = 1;
    mul("R9", 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 0, 0, 0);
    wrStat("R9", 8'h00);
    // R10: load beats saturate in the same cycle
    accLoad = 1; accLoadData = 64'hFFFF_0000_0000_0000;
    sat("R10", 2'd1, 0, 0, 1);
    // R12: read each accumulator
    for (int i = 0; i < 4; i++) begin
      accIdx = 2'(i);
      tick("R12");
    end

    // random mix against the reference
    for (int n = 0; n < 3000; n++) begin
      logic [63:0] d;
      d = {$urandom, $urandom};
      case ($urandom % 4)
        0: d = d >> ($urandom % 64);
        1: d = {{16{d[47]}}, d[47:0]};
        default: ;
      endcase
      mulGo = $urandom % 2;
      mulA = ($urandom % 2) ? $urandom : ($urandom >> ($urandom % 32));
      mulB = ($urandom % 2) ? $urandom : ($urandom >> ($urandom % 32));
      modeUnsigned = $urandom % 2; modeFrac = ($urandom % 3) == 0;
      modeRound = $urandom % 2; modeOmc = $urandom % 2;
      accIdx = 2'($urandom % 4);
      accLoad = ($urandom % 3) == 0; accLoadData = d;
      satGo = $urandom % 2;
      statWr = ($urandom % 8) == 0; statWrData = 8'($urandom);
      tick("R2");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule